// File: doc/BRIEF.md
# Programmable I/O and Memory Chip-Select Decoder

This block turns host bus cycles into active-low select lines for on-board peripherals and memory. It compares the 20-bit host address with a programmable window for each select. There are four I/O selects and two memory selects, and each has its own base, length and qualify bit. When the qualify bit is clear, a select asserts on an address match alone. When it is set, the select also needs a low command strobe of its own kind: I/O strobes for I/O selects, memory strobes for memory selects.

Every select belongs to one of two logical devices and only drives while that device's activate bit is set. I/O selects 2 and 3 exist only in the extended-interrupt operating mode. A high address-enable marks a DMA cycle, and no I/O select asserts during it. Loading the base and length values is done elsewhere; this block only reads them. All outputs are registered, so each select reflects the inputs sampled at the previous rising clock edge.

Top module: `csdec_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, every `io_cs_n` and `mem_cs_n` bit is 1 (inactive).
- R2: I/O select k matches when `host_addr[15:0]` satisfies base ≤ A < base+length. Bits 19:16 are ignored. The output reflects the inputs one rising edge later.
- R3: Memory select k matches when all 20 address bits satisfy base ≤ A < base+length.
- R4: With the qualify bit at 0, a match alone asserts the select. With it at 1, the select also needs at least one strobe of its kind (read or write) low.
- R5: I/O selects never qualify on `memr_n`/`memw_n`, and memory selects never qualify on `ior_n`/`iow_n`.
- R6: While `aen` is 1, every I/O select stays inactive. Memory selects are not affected by `aen`.
- R7: I/O selects 0 and 2 and memory select 0 follow `dev_active[0]`. I/O selects 1 and 3 and memory select 1 follow `dev_active[1]`. A select whose bit is 0 stays inactive.
- R8: A select whose base is zero never asserts.
- R9: I/O selects 2 and 3 can assert only when `mode` is 2'b01 (extended interrupt). For modes 2'b00 and 2'b10 they stay inactive.
- R10: The last address of a window (base+length−1) matches and base+length does not. A length of 0 never matches. The end of the window is computed one bit wider, so a window that ends exactly at the top of the address space still matches its last address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 20 | Host address |
| aen | input | 1 | Address enable, high during DMA cycles |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| mode | input | 2 | Operating mode (2'b01 = extended interrupt) |
| dev_active | input | 2 | Activate bit of logical devices 1 and 0 |
| io_base | input | 64 | Four 16-bit I/O bases, select k in bits [16k+15:16k] |
| io_len | input | 64 | Four 16-bit I/O window lengths |
| io_qual | input | 4 | Command-qualify bit per I/O select |
| mem_base | input | 40 | Two 20-bit memory bases |
| mem_len | input | 40 | Two 20-bit memory window lengths |
| mem_qual | input | 2 | Command-qualify bit per memory select |
| io_cs_n | output | 4 | I/O selects, active low |
| mem_cs_n | output | 2 | Memory selects, active low |

## Verification
The block holds no state beyond the output registers. A wrong decode therefore appears on the select pins exactly one clock after the offending address or strobe pattern. The stimulus places addresses on both sides of every window edge, and each input pattern is held for one cycle. An off-by-one compare, a swapped strobe group or a wrong device owner then shows up as a flipped select bit in the very next sample. Gating faults, such as the address-enable block, zero-base suppression and the mode dependence of selects 2 and 3, are checked in the same one-cycle way.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam logic [1:0] MODE_NORM_DMA = 2'b00;
  localparam logic [1:0] MODE_EXT_IRQ  = 2'b01;
  localparam logic [1:0] MODE_EXT_DMA  = 2'b10;
  localparam int unsigned HOST_AW = 20;
  localparam int unsigned IO_AW   = 16;
endpackage

// File: rtl/csdec_window.sv
module csdec_window #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic          hit
);
  logic [AW:0] win_end;
  always_comb begin
    win_end = {1'b0, base} + {1'b0, len};
    hit = (base != '0) && (addr >= base) && ({1'b0, addr} < win_end);
  end
endmodule

// File: rtl/csdec_slot.sv
module csdec_slot #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic          qual,
  input  logic          cmd_act,
  input  logic          enable,
  output logic          cs_n
);
  logic hit;
  logic fire;

  csdec_window #(.AW(AW)) u_win (
    .addr(addr), .base(base), .len(len), .hit(hit)
  );

  always_comb fire = enable && hit && (!qual || cmd_act);

  always_ff @(posedge clk) begin
    if (rst) cs_n <= 1'b1;
    else     cs_n <= !fire;
  end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int unsigned N_IO  = 4,
  parameter int unsigned N_MEM = 2,
  parameter int unsigned AW    = HOST_AW,
  parameter int unsigned IOW   = IO_AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        host_addr,
  input  logic                 aen,
  input  logic                 ior_n,
  input  logic                 iow_n,
  input  logic                 memr_n,
  input  logic                 memw_n,
  input  logic [1:0]           mode,
  input  logic [1:0]           dev_active,
  input  logic [N_IO*IOW-1:0]  io_base,
  input  logic [N_IO*IOW-1:0]  io_len,
  input  logic [N_IO-1:0]      io_qual,
  input  logic [N_MEM*AW-1:0]  mem_base,
  input  logic [N_MEM*AW-1:0]  mem_len,
  input  logic [N_MEM-1:0]     mem_qual,
  output logic [N_IO-1:0]      io_cs_n,
  output logic [N_MEM-1:0]     mem_cs_n
);
  localparam int unsigned BASE_IO = 2;

  logic io_cmd;
  logic mem_cmd;
  logic ext_mode;

  always_comb begin
    io_cmd   = !ior_n || !iow_n;
    mem_cmd  = !memr_n || !memw_n;
    ext_mode = (mode == MODE_EXT_IRQ);
  end

  for (genvar i = 0; i < N_IO; i++) begin : g_io
    logic en;
    if (i < BASE_IO) begin : g_base
      always_comb en = dev_active[i % 2] && !aen;
    end else begin : g_ext
      always_comb en = dev_active[i % 2] && !aen && ext_mode;
    end
    csdec_slot #(.AW(IOW)) u_slot (
      .clk(clk), .rst(rst),
      .addr(host_addr[IOW-1:0]),
      .base(io_base[i*IOW +: IOW]),
      .len(io_len[i*IOW +: IOW]),
      .qual(io_qual[i]),
      .cmd_act(io_cmd),
      .enable(en),
      .cs_n(io_cs_n[i])
    );
  end

  for (genvar j = 0; j < N_MEM; j++) begin : g_mem
    csdec_slot #(.AW(AW)) u_slot (
      .clk(clk), .rst(rst),
      .addr(host_addr),
      .base(mem_base[j*AW +: AW]),
      .len(mem_len[j*AW +: AW]),
      .qual(mem_qual[j]),
      .cmd_act(mem_cmd),
      .enable(dev_active[j % 2]),
      .cs_n(mem_cs_n[j])
    );
  end
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
  parameter int unsigned N_IO  = 4,
  parameter int unsigned N_MEM = 2,
  parameter int unsigned AW    = 20,
  parameter int unsigned IOW   = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                aen,
  input logic                ior_n,
  input logic                iow_n,
  input logic [1:0]          mode,
  input logic [1:0]          dev_active,
  input logic [N_IO-1:0]     io_qual,
  input logic [N_MEM*AW-1:0] mem_base,
  input logic [N_IO-1:0]     io_cs_n,
  input logic [N_MEM-1:0]    mem_cs_n
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&io_cs_n && &mem_cs_n)); // R1
  AST_AEN_BLOCKS_IO: assert property (@(posedge clk) disable iff (rst)
    $past(aen) |-> &io_cs_n); // R6
  AST_DEV0_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(dev_active[0]) |-> (io_cs_n[0] && io_cs_n[2] && mem_cs_n[0])); // R7
  AST_DEV1_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(dev_active[1]) |-> (io_cs_n[1] && io_cs_n[3] && mem_cs_n[1])); // R7
  AST_EXT_SEL_MODE: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) != 2'b01) |-> (&io_cs_n[N_IO-1:2])); // R9
  AST_QUAL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    ($past(io_qual[0]) && $past(ior_n) && $past(iow_n)) |-> io_cs_n[0]); // R4
  AST_ZERO_BASE: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_base[AW-1:0]) == '0) |-> mem_cs_n[0]); // R8
endmodule

bind csdec_top csdec_chk #(.N_IO(N_IO), .N_MEM(N_MEM), .AW(AW), .IOW(IOW)) u_chk (
  .clk(clk), .rst(rst), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
  .mode(mode), .dev_active(dev_active), .io_qual(io_qual),
  .mem_base(mem_base), .io_cs_n(io_cs_n), .mem_cs_n(mem_cs_n)
);

// File: tb/csdec_top_tb.sv
module csdec_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] host_addr = '0;
  logic        aen = 1'b0;
  logic        ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
  logic [1:0]  mode = 2'b01;
  logic [1:0]  dev_active = 2'b11;
  logic [63:0] io_base, io_len;
  logic [3:0]  io_qual;
  logic [39:0] mem_base, mem_len;
  logic [1:0]  mem_qual;
  logic [3:0]  io_cs_n;
  logic [1:0]  mem_cs_n;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  csdec_top u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .aen(aen),
    .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
    .mode(mode), .dev_active(dev_active),
    .io_base(io_base), .io_len(io_len), .io_qual(io_qual),
    .mem_base(mem_base), .mem_len(mem_len), .mem_qual(mem_qual),
    .io_cs_n(io_cs_n), .mem_cs_n(mem_cs_n)
  );

  // {addr, aen, {ior_n,iow_n,memr_n,memw_n}, expected io_cs_n, expected mem_cs_n}
  localparam int NV = 19;
  localparam logic [30:0] VEC [0:NV-1] = '{
    {20'h00300, 1'b0, 4'b1111, 4'b1110, 2'b11},
    {20'h3030F, 1'b0, 4'b1111, 4'b1110, 2'b11},
    {20'h00310, 1'b0, 4'b1111, 4'b1111, 2'b11},
    {20'h00310, 1'b0, 4'b0111, 4'b1101, 2'b11},
    {20'h00317, 1'b0, 4'b1011, 4'b1101, 2'b11},
    {20'h00318, 1'b0, 4'b1011, 4'b1111, 2'b11},
    {20'h00310, 1'b0, 4'b1101, 4'b1111, 2'b11},
    {20'h00223, 1'b0, 4'b1111, 4'b1011, 2'b11},
    {20'h00224, 1'b0, 4'b1111, 4'b1111, 2'b11},
    {20'h00300, 1'b1, 4'b1111, 4'b1111, 2'b11},
    {20'hC8000, 1'b1, 4'b1111, 4'b1111, 2'b10},
    {20'hCBFFF, 1'b0, 4'b1111, 4'b1111, 2'b10},
    {20'hCC000, 1'b0, 4'b1111, 4'b1111, 2'b11},
    {20'hD0000, 1'b0, 4'b1111, 4'b1111, 2'b11},
    {20'hD0000, 1'b0, 4'b1110, 4'b1111, 2'b01},
    {20'hD0FFF, 1'b0, 4'b1101, 4'b1111, 2'b01},
    {20'hD1000, 1'b0, 4'b1101, 4'b1111, 2'b11},
    {20'hD0000, 1'b0, 4'b0111, 4'b1111, 2'b11},
    {20'h00000, 1'b0, 4'b1111, 4'b1111, 2'b11}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:             return "R2";
      2, 3, 13, 14:     return "R4";
      4, 5, 8:          return "R10";
      6, 17:            return "R5";
      7:                return "R9";
      9, 10:            return "R6";
      11, 12, 15, 16:   return "R3";
      default:          return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic apply(logic [19:0] a, logic e, logic [3:0] s);
    @(negedge clk);
    host_addr = a; aen = e;
    {ior_n, iow_n, memr_n, memw_n} = s;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    io_base  = {16'h0000, 16'h0220, 16'h0310, 16'h0300};
    io_len   = {16'h0010, 16'h0004, 16'h0008, 16'h0010};
    io_qual  = 4'b0010;
    mem_base = {20'hD0000, 20'hC8000};
    mem_len  = {20'h01000, 20'h04000};
    mem_qual = 2'b10;
    host_addr = 20'h00300;
    repeat (3) @(negedge clk);
    check("R1 io in reset", io_cs_n, 4'b1111);
    check("R1 mem in reset", {2'b00, mem_cs_n}, 4'b0011);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 first cycle", io_cs_n, 4'b1110);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][30:11], VEC[i][10], VEC[i][9:6]);
      check(vtag(i), io_cs_n, VEC[i][5:2]);
      check(vtag(i), {2'b00, mem_cs_n}, {2'b00, VEC[i][1:0]});
    end

    // R9: normal DMA mode hides select 2
    mode = 2'b00;
    apply(20'h00220, 1'b0, 4'b1111);
    check("R9 mode00 io2", io_cs_n, 4'b1111);
    mode = 2'b10;
    apply(20'h00220, 1'b0, 4'b1111);
    check("R9 mode10 io2", io_cs_n, 4'b1111);
    mode = 2'b01;

    // R7: device 1 off, device 0 still decodes
    dev_active = 2'b01;
    apply(20'h00310, 1'b0, 4'b0111);
    check("R7 dev1 off io1", io_cs_n, 4'b1111);
    apply(20'h00300, 1'b0, 4'b1111);
    check("R7 dev0 on io0", io_cs_n, 4'b1110);
    apply(20'hD0000, 1'b0, 4'b1110);
    check("R7 dev1 off mem1", {2'b00, mem_cs_n}, 4'b0011);
    dev_active = 2'b10;
    apply(20'hC8000, 1'b0, 4'b1111);
    check("R7 dev0 off mem0", {2'b00, mem_cs_n}, 4'b0011);
    dev_active = 2'b11;

    // R10: zero length and window ending at top of space
    io_len[15:0] = 16'h0000;
    apply(20'h00300, 1'b0, 4'b1111);
    check("R10 zero len", io_cs_n, 4'b1111);
    mem_base[19:0] = 20'hFF000;
    mem_len[19:0]  = 20'h01000;
    apply(20'hFFFFF, 1'b0, 4'b1111);
    check("R10 top end", {2'b00, mem_cs_n}, 4'b0010);
    apply(20'hFEFFF, 1'b0, 4'b1111);
    check("R10 below base", {2'b00, mem_cs_n}, 4'b0011);

    // R8: zero memory base
    mem_base[19:0] = 20'h00000;
    apply(20'h00000, 1'b0, 4'b1111);
    check("R8 mem zero base", {2'b00, mem_cs_n}, 4'b0011);

    // R1: reset mid-run forces idle
    mem_base[19:0] = 20'hC8000;
    apply(20'hC8000, 1'b0, 4'b1111);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", {2'b00, mem_cs_n}, 4'b0011);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule